// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block sits between a PWM controller and the gate drivers of a synchronous buck power stage. It takes a decoded PWM level (low, high or tri-state), a decoded conduction-mode level (continuous, discontinuous or tri-state), two dead-time feedback comparator flags, a zero-cross flag and a supply-good flag. From these it produces the high-side and low-side gate enables. All inputs are asynchronous to the block clock.

Neither gate is switched on until the opposite side is confirmed off by its comparator flag, and each turn-on then waits a fixed blanking window. If a feedback flag never arrives, a timeout lets the transition go ahead and latches a fault bit. Short tri-state excursions on the PWM input are filtered out. A tri-state level that lasts longer shuts both gates off, and the block re-enters switching only after an exit delay. In discontinuous mode the low-side switch behaves like a diode: it opens once the inductor current reverses, but only after a minimum on time has elapsed.

All delays are counted in clock cycles. The defaults assume a 5 ns clock.

Top module: `hb_gate_seq`

## Requirements
- R1: In continuous mode (`mode_code` = 01), a settled high PWM command (`pwm_code` = 01) gives `hs_en`=1, `ls_en`=0, and a settled low command (`pwm_code` = 00) gives `hs_en`=0, `ls_en`=1. The two enables are never both 1.
- R2: `hs_en` rises only after a cycle in which the synchronized low-side-gate-below flag (`lsg_below`) was seen, followed by `HS_BLANK_CYC` (default 3) blanking cycles with both enables low.
- R3: `ls_en` rises only after a cycle in which the synchronized switch-node-below flag (`sw_below`) was seen, followed by `LS_BLANK_CYC` (default 3) blanking cycles with both enables low.
- R4: If the awaited feedback flag stays low for `FB_TIMEOUT_CYC` (default 64) cycles, the transition proceeds and `dt_fault` is set. `dt_fault` stays 1 until reset.
- R5: A tri-state PWM level (`pwm_code` = 10 or 11) forces both enables low only after it has been seen on `TRI_HOLD_CYC` (default 30) consecutive synchronized samples. Shorter excursions leave the outputs unchanged.
- R6: When the PWM input leaves tri-state, the new valid level takes effect only after it has been seen for `TRI_EXIT_CYC` (default 9) consecutive samples. Gate sequencing then follows R2/R3.
- R7: A tri-state mode level (`mode_code` = 10 or 11) forces both enables low, whatever the PWM level.
- R8: In discontinuous mode (`mode_code` = 00) with a low PWM command, `ls_en` is 1 while `zc_neg`=0. It drops once `zc_neg`=1 (negative inductor current). High-side behaviour is the same as in continuous mode.
- R9: In discontinuous mode, once `ls_en` rises it stays 1 for at least `LS_MIN_CYC` (default 70) cycles, even if `zc_neg` is already 1. A high PWM command or any forced shutdown may end it earlier.
- R10: While `supply_ok`=0, both enables are held low.
- R11: A synchronous active-high `rst` gives `hs_en`=0, `ls_en`=0 and `dt_fault`=0. Every input passes through two synchronizer flops, so a PWM edge in continuous mode drops the active gate after 4 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_code | input | 2 | Decoded PWM level: 00 low, 01 high, 1x tri-state |
| mode_code | input | 2 | Decoded mode level: 00 discontinuous, 01 continuous, 1x tri-state |
| lsg_below | input | 1 | Low-side gate voltage below 1 V |
| sw_below | input | 1 | Switch node voltage below 1 V |
| zc_neg | input | 1 | Inductor current negative (zero-cross passed) |
| supply_ok | input | 1 | Undervoltage lockout released |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| dt_fault | output | 1 | Sticky dead-time feedback timeout |

## Verification
The main sequencing is exercised in several ways, each aimed at a different part of the timing:
- Steady PWM toggling in continuous mode with both feedback flags present measures the pure pipeline, wait and blanking delay.
- Withholding one feedback flag separates the adaptive wait from the timeout path and shows the fault latch.
- Tri-state pulses just shorter and well longer than the holdoff tell glitch rejection apart from shutdown, and the return to a valid level exposes the exit delay.
- In discontinuous mode, holding the zero-cross flag low and then high separates diode emulation from complementary drive.
- Turning the low side on with the zero-cross flag already set isolates the minimum on time.

A long stretch of random levels on all inputs, including tri-state codes, is then compared cycle by cycle against a behavioural model.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Decoded three-level input
    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_TRI  = 2'd2
    } lvl_t;

    // Gate sequencing states
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HS_WAIT,
        ST_HS_BLANK,
        ST_HS_ON,
        ST_LS_WAIT,
        ST_LS_BLANK,
        ST_LS_ON,
        ST_LS_IDLE
    } gstate_t;

    // Raw input bundle, MSB first
    typedef struct packed {
        logic       supply_ok;
        logic       zc_neg;
        logic       sw_below;
        logic       lsg_below;
        logic [1:0] mode;
        logic [1:0] pwm;
    } raw_in_t;

    localparam int RAW_W = $bits(raw_in_t);

    function automatic lvl_t decode_lvl(input logic [1:0] code);
        if (code[1])
            return LVL_TRI;
        else if (code[0])
            return LVL_HIGH;
        else
            return LVL_LOW;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[b] <= 1'b0;
                q[b]    <= 1'b0;
            end else begin
                meta[b] <= d[b];
                q[b]    <= meta[b];
            end
        end
    end

endmodule

// File: rtl/hbg_tri_filter.sv
module hbg_tri_filter
    import hbg_pkg::*;
#(
    parameter int HOLD_CYC = 30,
    parameter int EXIT_CYC = 9
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t lvl_in,
    output lvl_t cmd
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int XW = $clog2(EXIT_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [XW-1:0] EXIT_LAST = XW'(EXIT_CYC - 1);

    logic [HW-1:0] hold_cnt;
    logic [XW-1:0] exit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= LVL_TRI;
            hold_cnt <= '0;
            exit_cnt <= '0;
        end else if (lvl_in == LVL_TRI) begin
            exit_cnt <= '0;
            if (cmd != LVL_TRI) begin
                if (hold_cnt == HOLD_LAST) begin
                    cmd      <= LVL_TRI;
                    hold_cnt <= '0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end else begin
            hold_cnt <= '0;
            if (cmd == LVL_TRI) begin
                if (exit_cnt == EXIT_LAST) begin
                    cmd      <= lvl_in;
                    exit_cnt <= '0;
                end else begin
                    exit_cnt <= exit_cnt + 1'b1;
                end
            end else begin
                cmd <= lvl_in;
            end
        end
    end

endmodule

// File: rtl/hbg_core.sv
module hbg_core
    import hbg_pkg::*;
#(
    parameter int HS_BLANK_CYC   = 3,
    parameter int LS_BLANK_CYC   = 3,
    parameter int LS_MIN_CYC     = 70,
    parameter int FB_TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t cmd,
    input  lvl_t mode,
    input  logic supply_ok,
    input  logic lsg_below,
    input  logic sw_below,
    input  logic zc_neg,
    output logic hs_en,
    output logic ls_en,
    output logic dt_fault
);

    localparam int CNT_MAXV = max2(max2(HS_BLANK_CYC, LS_BLANK_CYC),
                                   max2(LS_MIN_CYC, FB_TIMEOUT_CYC));
    localparam int CW = $clog2(CNT_MAXV + 1);
    localparam logic [CW-1:0] HSB_LAST = CW'(HS_BLANK_CYC - 1);
    localparam logic [CW-1:0] LSB_LAST = CW'(LS_BLANK_CYC - 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(LS_MIN_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(FB_TIMEOUT_CYC - 1);

    gstate_t       st, nxt;
    logic [CW-1:0] cnt;
    logic          tmo_hit;
    logic          force_off;

    assign force_off = !supply_ok || (mode == LVL_TRI) || (cmd == LVL_TRI);

    always_comb begin
        nxt     = st;
        tmo_hit = 1'b0;
        if (force_off) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:
                    nxt = (cmd == LVL_HIGH) ? ST_HS_WAIT : ST_LS_WAIT;
                ST_HS_WAIT:
                    if (cmd == LVL_LOW)
                        nxt = ST_LS_WAIT;
                    else if (lsg_below)
                        nxt = ST_HS_BLANK;
                    else if (cnt == TMO_LAST) begin
                        nxt     = ST_HS_BLANK;
                        tmo_hit = 1'b1;
                    end
                ST_HS_BLANK:
                    if (cmd == LVL_LOW)
                        nxt = ST_LS_WAIT;
                    else if (cnt == HSB_LAST)
                        nxt = ST_HS_ON;
                ST_HS_ON:
                    if (cmd == LVL_LOW)
                        nxt = ST_LS_WAIT;
                ST_LS_WAIT:
                    if (cmd == LVL_HIGH)
                        nxt = ST_HS_WAIT;
                    else if (sw_below)
                        nxt = ST_LS_BLANK;
                    else if (cnt == TMO_LAST) begin
                        nxt     = ST_LS_BLANK;
                        tmo_hit = 1'b1;
                    end
                ST_LS_BLANK:
                    if (cmd == LVL_HIGH)
                        nxt = ST_HS_WAIT;
                    else if (cnt == LSB_LAST)
                        nxt = ST_LS_ON;
                ST_LS_ON:
                    if (cmd == LVL_HIGH)
                        nxt = ST_HS_WAIT;
                    else if ((mode == LVL_LOW) && zc_neg && (cnt >= MIN_LAST))
                        nxt = ST_LS_IDLE;
                ST_LS_IDLE:
                    if (cmd == LVL_HIGH)
                        nxt = ST_HS_WAIT;
                    else if (mode == LVL_HIGH)
                        nxt = ST_LS_WAIT;
                default:
                    nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            cnt      <= '0;
            dt_fault <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt != st)
                cnt <= '0;
            else if (cnt != '1)
                cnt <= cnt + 1'b1;
            if (tmo_hit)
                dt_fault <= 1'b1;
        end
    end

    assign hs_en = (st == ST_HS_ON);
    assign ls_en = (st == ST_LS_ON);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hbg_pkg::*;
#(
    parameter int HS_BLANK_CYC   = 3,
    parameter int LS_BLANK_CYC   = 3,
    parameter int TRI_HOLD_CYC   = 30,
    parameter int TRI_EXIT_CYC   = 9,
    parameter int LS_MIN_CYC     = 70,
    parameter int FB_TIMEOUT_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwm_code,
    input  logic [1:0] mode_code,
    input  logic       lsg_below,
    input  logic       sw_below,
    input  logic       zc_neg,
    input  logic       supply_ok,
    output logic       hs_en,
    output logic       ls_en,
    output logic       dt_fault
);

    raw_in_t raw_a;
    raw_in_t raw_s;
    lvl_t    pwm_lvl;
    lvl_t    mode_lvl;
    lvl_t    cmd_lvl;

    assign raw_a = {supply_ok, zc_neg, sw_below, lsg_below, mode_code, pwm_code};

    hbg_sync #(.W(RAW_W)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_a),
        .q   (raw_s)
    );

    assign pwm_lvl  = decode_lvl(raw_s.pwm);
    assign mode_lvl = decode_lvl(raw_s.mode);

    hbg_tri_filter #(
        .HOLD_CYC (TRI_HOLD_CYC),
        .EXIT_CYC (TRI_EXIT_CYC)
    ) i_filter (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (pwm_lvl),
        .cmd    (cmd_lvl)
    );

    hbg_core #(
        .HS_BLANK_CYC   (HS_BLANK_CYC),
        .LS_BLANK_CYC   (LS_BLANK_CYC),
        .LS_MIN_CYC     (LS_MIN_CYC),
        .FB_TIMEOUT_CYC (FB_TIMEOUT_CYC)
    ) i_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_lvl),
        .mode      (mode_lvl),
        .supply_ok (raw_s.supply_ok),
        .lsg_below (raw_s.lsg_below),
        .sw_below  (raw_s.sw_below),
        .zc_neg    (raw_s.zc_neg),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .dt_fault  (dt_fault)
    );

endmodule

// File: rtl/hbg_check.sv
module hbg_check #(
    parameter int HOLD = 30,
    parameter int MIN_LS = 70
) (
    input logic       clk,
    input logic       rst,
    input logic       hs_en,
    input logic       ls_en,
    input logic       dt_fault,
    input logic       supply_ok,
    input logic [1:0] mode_code,
    input logic       pwm_tri_s,
    input logic       cmd_tri,
    input logic       cmd_high,
    input logic       mode_tri_s,
    input logic       ok_s
);

    logic [15:0] tri_run;
    logic [15:0] ls_run;
    logic        stop_cause;

    assign stop_cause = cmd_high || cmd_tri || mode_tri_s || !ok_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_run <= '0;
            ls_run  <= '0;
        end else begin
            if (!pwm_tri_s)
                tri_run <= '0;
            else if (tri_run < 16'(HOLD))
                tri_run <= tri_run + 1'b1;
            if (!ls_en)
                ls_run <= '0;
            else if (ls_run < 16'(MIN_LS))
                ls_run <= ls_run + 1'b1;
        end
    end

    assert_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_hs_gap_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> (!$past(ls_en) && !$past(ls_en, 2)));

    assert_ls_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> (!$past(hs_en) && !$past(hs_en, 2)));

    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        dt_fault |=> dt_fault);

    assert_tri_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_tri) |-> (tri_run >= 16'(HOLD)));

    assert_mode_off_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_code[1]) && $past(mode_code[1], 2) && $past(mode_code[1], 3))
        |-> (!hs_en && !ls_en));

    assert_min_on_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(ls_en) && (ls_run < 16'(MIN_LS))) |-> $past(stop_cause));

    assert_uvlo_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(supply_ok) && !$past(supply_ok, 2) && !$past(supply_ok, 3))
        |-> (!hs_en && !ls_en));

endmodule

bind hb_gate_seq hbg_check #(
    .HOLD   (TRI_HOLD_CYC),
    .MIN_LS (LS_MIN_CYC)
) i_check (
    .clk        (clk),
    .rst        (rst),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .dt_fault   (dt_fault),
    .supply_ok  (supply_ok),
    .mode_code  (mode_code),
    .pwm_tri_s  (pwm_lvl == hbg_pkg::LVL_TRI),
    .cmd_tri    (cmd_lvl == hbg_pkg::LVL_TRI),
    .cmd_high   (cmd_lvl == hbg_pkg::LVL_HIGH),
    .mode_tri_s (mode_lvl == hbg_pkg::LVL_TRI),
    .ok_s       (raw_s.supply_ok)
);

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;

    localparam int CLK_PERIOD = 10;
    localparam int HSB  = 3;
    localparam int LSB  = 3;
    localparam int HOLD = 30;
    localparam int EXIT = 9;
    localparam int MINL = 70;
    localparam int TMO  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwm_code = 2'b00;
    logic [1:0] mode_code = 2'b01;
    logic       lsg_below = 1'b1;
    logic       sw_below = 1'b1;
    logic       zc_neg = 1'b0;
    logic       supply_ok = 1'b0;
    logic       hs_en, ls_en, dt_fault;

    int    vectors = 0;
    int    miss = 0;
    int    cycles = 0;
    string cur_req = "R11";

    always #(CLK_PERIOD / 2) clk = ~clk;

    hb_gate_seq #(
        .HS_BLANK_CYC   (HSB),
        .LS_BLANK_CYC   (LSB),
        .TRI_HOLD_CYC   (HOLD),
        .TRI_EXIT_CYC   (EXIT),
        .LS_MIN_CYC     (MINL),
        .FB_TIMEOUT_CYC (TMO)
    ) i_hb_gate_seq (
        .clk       (clk),
        .rst       (rst),
        .pwm_code  (pwm_code),
        .mode_code (mode_code),
        .lsg_below (lsg_below),
        .sw_below  (sw_below),
        .zc_neg    (zc_neg),
        .supply_ok (supply_ok),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .dt_fault  (dt_fault)
    );

    // Behavioural reference: phases 0 off, 1 hs wait, 2 hs blank, 3 hs on,
    // 4 ls wait, 5 ls blank, 6 ls on, 7 ls idle. Levels 0 low, 1 high, 2 tri.
    logic [7:0] pipe[$];
    int m_cmd = 2, m_phase = 0, m_age = 0, m_trin = 0, m_exn = 0;
    bit m_fault = 0;

    always @(posedge clk) begin
        logic [7:0] smp;
        int p, md, np;
        bit timed;
        if (rst) begin
            pipe = {};
            pipe.push_back(8'h00);
            pipe.push_back(8'h00);
            m_cmd = 2; m_phase = 0; m_age = 0; m_trin = 0; m_exn = 0; m_fault = 0;
        end else begin
            smp = pipe[0];
            p  = smp[1] ? 2 : (smp[0] ? 1 : 0);
            md = smp[3] ? 2 : (smp[2] ? 1 : 0);
            np = m_phase;
            timed = 0;
            if (!smp[7] || md == 2 || m_cmd == 2) np = 0;
            else if (m_phase == 0) np = (m_cmd == 1) ? 1 : 4;
            else if (m_phase == 1 || m_phase == 2 || m_phase == 3) begin
                if (m_cmd == 0) np = 4;
                else if (m_phase == 1 && smp[4]) np = 2;
                else if (m_phase == 1 && m_age == TMO - 1) begin np = 2; timed = 1; end
                else if (m_phase == 2 && m_age == HSB - 1) np = 3;
            end else begin
                if (m_cmd == 1) np = 1;
                else if (m_phase == 4 && smp[5]) np = 5;
                else if (m_phase == 4 && m_age == TMO - 1) begin np = 5; timed = 1; end
                else if (m_phase == 5 && m_age == LSB - 1) np = 6;
                else if (m_phase == 6 && md == 0 && smp[6] && m_age >= MINL - 1) np = 7;
                else if (m_phase == 7 && md == 1) np = 4;
            end
            if (np != m_phase) m_age = 0;
            else if (m_age < 1000) m_age++;
            m_phase = np;
            if (timed) m_fault = 1;
            if (p == 2) begin
                m_exn = 0;
                if (m_cmd != 2) begin
                    m_trin++;
                    if (m_trin == HOLD) begin m_cmd = 2; m_trin = 0; end
                end
            end else begin
                m_trin = 0;
                if (m_cmd == 2) begin
                    m_exn++;
                    if (m_exn == EXIT) begin m_cmd = p; m_exn = 0; end
                end else m_cmd = p;
            end
            void'(pipe.pop_front());
            pipe.push_back({supply_ok, zc_neg, sw_below, lsg_below, mode_code, pwm_code});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vectors++;
            if (hs_en !== (m_phase == 3) || ls_en !== (m_phase == 6) || dt_fault !== m_fault) begin
                miss++;
                $display("FAIL %s: hs/ls/fault=%b%b%b expected %b%b%b", cur_req,
                         hs_en, ls_en, dt_fault, m_phase == 3, m_phase == 6, m_fault);
            end
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miss++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        // R11 reset state
        step(4);
        chk("R11 hs after reset", hs_en, 1'b0);
        chk("R11 ls after reset", ls_en, 1'b0);
        chk("R11 fault after reset", dt_fault, 1'b0);
        rst = 1'b0;

        // R10 supply not good
        cur_req = "R10";
        pwm_code = 2'b01;
        step(40);
        chk("R10 hs held low", hs_en, 1'b0);
        chk("R10 ls held low", ls_en, 1'b0);

        // R1 / R2 continuous operation
        cur_req = "R2";
        supply_ok = 1'b1;
        step(30);
        chk("R1 hs on for high command", hs_en, 1'b1);
        chk("R1 ls off for high command", ls_en, 1'b0);
        cur_req = "R3";
        pwm_code = 2'b00;
        step(20);
        chk("R1 ls on for low command", ls_en, 1'b1);
        chk("R1 hs off for low command", hs_en, 1'b0);

        // R11 latency through synchronizer, filter and state
        pwm_code = 2'b01;
        step(20);
        pwm_code = 2'b00;
        n = 0;
        while (hs_en && n < 20) begin step(1); n++; end
        chk_int("R11 edge-to-gate latency", n, 4);

        cur_req = "R1";
        for (int k = 0; k < 6; k++) begin
            pwm_code = 2'b01; step(10 + k);
            pwm_code = 2'b00; step(15 - k);
        end

        // R4 feedback timeout
        cur_req = "R4";
        lsg_below = 1'b0;
        pwm_code = 2'b01;
        step(6);
        chk("R4 no fault before timeout", dt_fault, 1'b0);
        step(80);
        chk("R4 fault after timeout", dt_fault, 1'b1);
        chk("R4 hs on after timeout", hs_en, 1'b1);
        lsg_below = 1'b1;
        sw_below = 1'b0;
        pwm_code = 2'b00;
        step(90);
        chk("R4 ls on after timeout", ls_en, 1'b1);
        chk("R4 fault sticky", dt_fault, 1'b1);
        sw_below = 1'b1;
        rst = 1'b1; step(3); rst = 1'b0;
        chk("R11 fault cleared by reset", dt_fault, 1'b0);
        pwm_code = 2'b01;
        step(30);

        // R5 tri-state glitch then long tri-state
        cur_req = "R5";
        pwm_code = 2'b10;
        step(20);
        chk("R5 short tri-state ignored", hs_en, 1'b1);
        pwm_code = 2'b01;
        step(10);
        chk("R5 hs still on after glitch", hs_en, 1'b1);
        pwm_code = 2'b11;
        step(40);
        chk("R5 hs off after holdoff", hs_en, 1'b0);
        chk("R5 ls off after holdoff", ls_en, 1'b0);

        // R6 exit delay
        cur_req = "R6";
        pwm_code = 2'b01;
        step(6);
        chk("R6 hs still off during exit delay", hs_en, 1'b0);
        step(24);
        chk("R6 hs on after exit delay", hs_en, 1'b1);

        // R7 mode tri-state
        cur_req = "R7";
        mode_code = 2'b10;
        step(10);
        chk("R7 hs off for tri mode", hs_en, 1'b0);
        pwm_code = 2'b00;
        step(10);
        chk("R7 ls off for tri mode", ls_en, 1'b0);

        // R8 diode emulation
        cur_req = "R8";
        mode_code = 2'b00;
        zc_neg = 1'b0;
        step(100);
        chk("R8 ls on with positive current", ls_en, 1'b1);
        zc_neg = 1'b1;
        step(10);
        chk("R8 ls off after zero cross", ls_en, 1'b0);
        chk("R8 hs stays off", hs_en, 1'b0);
        pwm_code = 2'b01;
        step(20);
        chk("R8 hs follows high command", hs_en, 1'b1);

        // R9 minimum low-side on time
        cur_req = "R9";
        pwm_code = 2'b00;
        n = 0;
        while (!ls_en && n < 40) begin step(1); n++; end
        n = 0;
        while (ls_en && n < 200) begin step(1); n++; end
        chk_int("R9 ls on time with early zero cross", n, MINL);

        // Random mix compared against the model
        cur_req = "R1";
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom_range(0, 9);
            pwm_code  = (r < 1) ? 2'b10 : ((r < 5) ? 2'b00 : 2'b01);
            r = $urandom_range(0, 19);
            mode_code = (r == 0) ? 2'b11 : ((r < 10) ? 2'b00 : 2'b01);
            lsg_below = ($urandom_range(0, 9) != 0);
            sw_below  = ($urandom_range(0, 9) != 0);
            zc_neg    = $urandom_range(0, 1);
            supply_ok = ($urandom_range(0, 29) != 0);
            step($urandom_range(1, 45));
        end
        finish_run();
    end

endmodule